// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped, looking only at its 48-bit destination address. The receive path presents the whole address as one word with a one-cycle strobe. One clock later the block returns a keep/drop verdict and a separate flag that reports whether the address failed the filter.

Software-visible state is loaded through a plain write port. This state covers four mode bits, a 64-entry multicast hash table held as two 32-bit words, and a set of perfect-match unicast entries. Entry 0 is meant for the station's own address, and the remaining entries hold extra addresses.

Multicast frames can be accepted in two ways: through the hash table, or wholesale by a pass-all-multicast mode. A promiscuous mode accepts everything. A receive-all mode forwards every frame but still reports the honest filter result on the fail flag.

Top module: `rx_da_filter`

## Requirements
- R1: Writes take effect on the clock edge where `wr_en_i` is high, and a strobe in any later cycle sees the new value. The register map is as follows:
  - Address 0 is the mode word: bit 0 promiscuous, bit 1 pass-all-multicast, bit 2 hash enable, bit 3 receive-all.
  - Address 1 is hash bits 31:0 and address 2 is hash bits 63:32.
  - Unicast entry i sits at address 16+2i, holding address bits 47:16.
  - Entry i also uses address 17+2i: bits 15:0 hold address bits 15:0, and bit 31 enables the entry.
- R2: A non-multicast address equal to the 48-bit value of any enabled unicast entry is accepted. An address matching only a disabled entry, or no entry, is not accepted.
- R3: With promiscuous mode set, every address is accepted, the verdict is keep and the fail flag is low.
- R4: The hash index is computed from the six address bytes, first byte in `da_i[47:40]`, each byte processed LSB first.
  - The CRC-32 is reflected (polynomial 0xEDB88320), seeded with all ones, and has no final inversion.
  - Index bit 5-k equals the inverse of CRC bit k, for k from 0 to 5.
  - Index bit 5 selects the high word (1) or the low word (0). The low 5 bits select the bit within that word.
  - A multicast address is accepted when hashing is enabled and the selected table bit is 1.
- R5: When hash enable is clear, a multicast address is never accepted through the hash table, whatever the table holds.
- R6: With pass-all-multicast set, every multicast address is accepted (bit 0 of the first byte, `da_i[40]`, set). Unicast addresses are still filtered normally.
- R7: The broadcast address (all ones) is always accepted.
- R8: With receive-all set, the verdict is always keep, while the fail flag still shows whether the address was rejected by the filter.
- R9: `res_valid_o` is high exactly one cycle after `da_valid_i`. In that cycle `da_fail_o` is the inverse of acceptance, and `pass_o` is acceptance OR receive-all. In every other cycle all three outputs are low.
- R10: After reset all state is cleared: no modes, an empty hash table and no enabled entries. Outputs are low, so a unicast address then fails and only broadcast passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 32 | Register write data |
| da_valid_i | input | 1 | Destination address valid strobe |
| da_i | input | 48 | Destination address, first byte in bits 47:40 |
| res_valid_o | output | 1 | Verdict valid |
| pass_o | output | 1 | Keep the frame |
| da_fail_o | output | 1 | Destination address failed the filter |

## Verification
The in-design properties assume the register state does not change in the same cycle as an address strobe. The verdict is taken from the register contents present at the strobe edge, so a simultaneous write would make the reference ambiguous. The properties also assume that inputs are known once reset is released.

The stimulus therefore spaces every write and every address strobe into cycles of their own. It drives all inputs shortly after the rising edge, so they are settled well before the next capture. Multicast test addresses are chosen by searching for values whose hash lands in the low word or in the high word, so both table halves and their separation are exercised.

// File: rtl/rxdaf_pkg.sv
`timescale 1ns/1ps
package rxdaf_pkg;

   localparam int MAC_W      = 48;
   localparam int REG_W      = 32;
   localparam int HASH_IDX_W = 6;
   localparam int HASH_W     = 2 * REG_W;
   localparam int MAC_BYTES  = MAC_W / 8;
   localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

   // packed: promisc lands on bit 0, recv_all on bit 3
   typedef struct packed {
      logic recv_all;
      logic hash_en;
      logic pass_mcast;
      logic promisc;
   } flt_mode_t;

   localparam int MODE_W = $bits(flt_mode_t);

   // bit-serial reflected CRC over the address bytes, first byte first, LSB first
   function automatic logic [HASH_IDX_W-1:0] mcast_hash_idx(input logic [MAC_W-1:0] da);
      logic [31:0] c;
      logic        fb;
      logic [HASH_IDX_W-1:0] idx;
      c = '1;
      for (int b = 0; b < MAC_BYTES; b++) begin
         for (int k = 0; k < 8; k++) begin
            fb = c[0] ^ da[MAC_W - 8 - 8*b + k];
            c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY_R : 32'h0);
         end
      end
      for (int i = 0; i < HASH_IDX_W; i++) idx[HASH_IDX_W-1-i] = ~c[i];
      return idx;
   endfunction

endpackage

// File: rtl/rxdaf_regs.sv
`timescale 1ns/1ps
module rxdaf_regs
   import rxdaf_pkg::*;
#(
   parameter int NUM_UC  = 16,
   parameter int ADDR_W  = 6,
   parameter int UC_BASE = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [REG_W-1:0]              wr_data,
   output flt_mode_t                     mode_o,
   output logic [HASH_W-1:0]             hash_o,
   output logic [NUM_UC-1:0][MAC_W-1:0]  uc_addr_o,
   output logic [NUM_UC-1:0]             uc_en_o
);

   localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] HLO_A  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] HHI_A  = ADDR_W'(2);
   localparam int LO_PART = MAC_W - REG_W;

   if (UC_BASE + 2*NUM_UC > (1 << ADDR_W)) begin : g_chk_map
      $error("rxdaf_regs: address space too small for unicast entries");
   end
   if (UC_BASE < 3) begin : g_chk_base
      $error("rxdaf_regs: unicast base overlaps mode/hash words");
   end

   flt_mode_t          mode_q;
   logic [HASH_W-1:0]  hash_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         hash_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == MODE_A) mode_q <= flt_mode_t'(wr_data[MODE_W-1:0]);
         if (wr_addr == HLO_A)  hash_q[REG_W-1:0] <= wr_data;
         if (wr_addr == HHI_A)  hash_q[HASH_W-1:REG_W] <= wr_data;
      end
   end

   assign mode_o = mode_q;
   assign hash_o = hash_q;

   for (genvar i = 0; i < NUM_UC; i++) begin : g_entry
      localparam logic [ADDR_W-1:0] ENT_HI_A = ADDR_W'(UC_BASE + 2*i);
      localparam logic [ADDR_W-1:0] ENT_LO_A = ADDR_W'(UC_BASE + 2*i + 1);
      logic [REG_W-1:0]   upper_q;
      logic [LO_PART-1:0] lower_q;
      logic               en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
            en_q    <= 1'b0;
         end else if (wr_en) begin
            if (wr_addr == ENT_HI_A) upper_q <= wr_data;
            if (wr_addr == ENT_LO_A) begin
               lower_q <= wr_data[LO_PART-1:0];
               en_q    <= wr_data[REG_W-1];
            end
         end
      end
      assign uc_addr_o[i] = {upper_q, lower_q};
      assign uc_en_o[i]   = en_q;
   end

   p_mode_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == MODE_A) |=> (mode_o == $past(wr_data[MODE_W-1:0])));
   p_hash_hi_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == HHI_A) |=> (hash_o[HASH_W-1:REG_W] == $past(wr_data)));
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(hash_o) && $stable(mode_o) && $stable(uc_en_o)));

endmodule

// File: rtl/rxdaf_hash.sv
`timescale 1ns/1ps
module rxdaf_hash
   import rxdaf_pkg::*;
(
   input  logic [MAC_W-1:0]  da,
   input  logic [HASH_W-1:0] table_i,
   output logic              hit_o
);

   if (HASH_W != (1 << HASH_IDX_W)) begin : g_chk_tbl
      $error("rxdaf_hash: table size does not match index width");
   end

   logic [HASH_IDX_W-1:0] idx;

   always_comb begin
      idx   = mcast_hash_idx(da);
      // idx msb picks the upper 32-bit word, lower bits pick the bit
      hit_o = table_i[idx];
   end

endmodule

// File: rtl/rxdaf_uc_match.sv
`timescale 1ns/1ps
module rxdaf_uc_match
   import rxdaf_pkg::*;
#(
   parameter int NUM_UC = 16
) (
   input  logic [MAC_W-1:0]              da,
   input  logic [NUM_UC-1:0][MAC_W-1:0]  uc_addr,
   input  logic [NUM_UC-1:0]             uc_en,
   output logic                          hit_o
);

   logic [NUM_UC-1:0] eq;

   for (genvar i = 0; i < NUM_UC; i++) begin : g_cmp
      assign eq[i] = uc_en[i] && (uc_addr[i] == da);
   end

   assign hit_o = |eq;

endmodule

// File: rtl/rx_da_filter.sv
`timescale 1ns/1ps
module rx_da_filter
   import rxdaf_pkg::*;
#(
   parameter int NUM_UC = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [31:0]       wr_data_i,
   input  logic              da_valid_i,
   input  logic [47:0]       da_i,
   output logic              res_valid_o,
   output logic              pass_o,
   output logic              da_fail_o
);

   if (NUM_UC < 1 || NUM_UC > 16) begin : g_chk_uc
      $error("rx_da_filter: NUM_UC must be 1..16");
   end

   flt_mode_t                     mode;
   logic [HASH_W-1:0]             hash_tbl;
   logic [NUM_UC-1:0][MAC_W-1:0]  uc_addr;
   logic [NUM_UC-1:0]             uc_en;
   logic                          uc_hit, hash_hit, is_mcast, is_bcast, accept;

   rxdaf_regs #(.NUM_UC(NUM_UC), .ADDR_W(ADDR_W), .UC_BASE(16)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
      .wr_data(wr_data_i), .mode_o(mode), .hash_o(hash_tbl),
      .uc_addr_o(uc_addr), .uc_en_o(uc_en)
   );

   rxdaf_hash u_hash (.da(da_i), .table_i(hash_tbl), .hit_o(hash_hit));

   rxdaf_uc_match #(.NUM_UC(NUM_UC)) u_match (
      .da(da_i), .uc_addr(uc_addr), .uc_en(uc_en), .hit_o(uc_hit)
   );

   always_comb begin
      is_mcast = da_i[MAC_W-8];
      is_bcast = &da_i;
      accept   = mode.promisc | is_bcast
               | (!is_mcast && uc_hit)
               | (is_mcast && (mode.pass_mcast || (mode.hash_en && hash_hit)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid_o <= 1'b0;
         pass_o      <= 1'b0;
         da_fail_o   <= 1'b0;
      end else begin
         res_valid_o <= da_valid_i;
         pass_o      <= da_valid_i && (accept || mode.recv_all);
         da_fail_o   <= da_valid_i && !accept;
      end
   end

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid_i |=> res_valid_o);
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid_i |=> (!res_valid_o && !pass_o && !da_fail_o));
   p_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid_i && mode.promisc) |=> (pass_o && !da_fail_o));
   p_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid_i && (&da_i)) |=> (pass_o && !da_fail_o));
   p_recv_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid_i && mode.recv_all) |=> pass_o);
   p_fail_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && da_fail_o && pass_o) |-> $past(mode.recv_all));
   p_hash_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid_i && da_i[MAC_W-8] && !(&da_i) && !mode.hash_en
       && !mode.pass_mcast && !mode.promisc) |=> da_fail_o);

endmodule

// File: tb/rx_da_filter_test.sv
`timescale 1ns/1ps
module rx_da_filter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [5:0]  wr_addr_i = '0;
   logic [31:0] wr_data_i = '0;
   logic        da_valid_i = 1'b0;
   logic [47:0] da_i = '0;
   logic        res_valid_o, pass_o, da_fail_o;

   always #4 clk = ~clk;

   rx_da_filter uut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .da_valid_i(da_valid_i), .da_i(da_i),
      .res_valid_o(res_valid_o), .pass_o(pass_o), .da_fail_o(da_fail_o)
   );

   // behavioural model state
   logic [3:0]  m_mode = '0;
   logic [63:0] m_hash = '0;
   logic [47:0] m_ua [16];
   bit          m_ue [16];

   int    total = 0, bad = 0;
   bit    done = 0;
   string cur_tag = "R10";
   string exp_tag = "R10";
   bit    exp_v = 0, exp_p = 0, exp_f = 0;

   function automatic logic [5:0] ref_index(input logic [47:0] d);
      logic [31:0] c, r, rv;
      c = 32'hFFFF_FFFF;
      for (int b = 0; b < 6; b++) begin
         c = c ^ {24'h0, d[47-8*b -: 8]};
         for (int s = 0; s < 8; s++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      r = ~c;
      for (int i = 0; i < 32; i++) rv[31-i] = r[i];
      return rv[31:26];
   endfunction

   function automatic bit ref_ok(input logic [47:0] d);
      if (m_mode[0]) return 1;
      if (d == 48'hFFFF_FFFF_FFFF) return 1;
      if (d[40]) return m_mode[1] || (m_mode[2] && m_hash[ref_index(d)]);
      for (int i = 0; i < 16; i++) if (m_ue[i] && m_ua[i] == d) return 1;
      return 0;
   endfunction

   function automatic logic [47:0] pick_mcast(input bit want_hi);
      for (int x = 0; x < 256; x++) begin
         logic [47:0] d;
         d = {40'h01_005E_0000, x[7:0]};
         if (ref_index(d)[5] == want_hi) return d;
      end
      return 48'h01_005E_0000_00;
   endfunction

   // compare on every clock, away from the rising edge
   always @(negedge clk) begin
      if (!done) begin
         total++;
         if (res_valid_o !== exp_v || pass_o !== exp_p || da_fail_o !== exp_f) begin
            bad++;
            $display("FAIL %s valid/pass/fail act=%b%b%b exp=%b%b%b",
                     exp_tag, res_valid_o, pass_o, da_fail_o, exp_v, exp_p, exp_f);
         end
         if (!rst_n) begin
            exp_v = 0; exp_p = 0; exp_f = 0; exp_tag = "R10";
         end else if (da_valid_i) begin
            bit ok;
            ok = ref_ok(da_i);
            exp_v = 1; exp_p = ok || m_mode[3]; exp_f = !ok; exp_tag = cur_tag;
         end else begin
            exp_v = 0; exp_p = 0; exp_f = 0; exp_tag = "R9";
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(posedge clk); #2;
      da_valid_i = 0; wr_en_i = 1; wr_addr_i = a[5:0]; wr_data_i = d;
      if (a == 0) m_mode = d[3:0];
      else if (a == 1) m_hash[31:0] = d;
      else if (a == 2) m_hash[63:32] = d;
      else if (a >= 16 && a < 48) begin
         if (a % 2 == 0) m_ua[(a-16)/2][47:16] = d;
         else begin
            m_ua[(a-16)/2][15:0] = d[15:0];
            m_ue[(a-16)/2] = d[31];
         end
      end
   endtask

   task automatic set_uc(input int i, input logic [47:0] mac, input bit en);
      wr(16 + 2*i, mac[47:16]);
      wr(17 + 2*i, {en, 15'h0, mac[15:0]});
   endtask

   task automatic probe(input logic [47:0] d, input string tag);
      @(posedge clk); #2;
      wr_en_i = 0; da_valid_i = 1; da_i = d; cur_tag = tag;
   endtask

   task automatic idle();
      @(posedge clk); #2;
      wr_en_i = 0; da_valid_i = 0;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1;
         bad++;
         $display("FAIL R9 watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [47:0] sta, ma, mb;
      for (int i = 0; i < 16; i++) begin m_ua[i] = '0; m_ue[i] = 0; end
      sta = 48'h02_11_22_33_44_55;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      idle();
      // R10: cleared state, unicast fails, broadcast passes
      probe(sta, "R10");
      probe(48'hFFFF_FFFF_FFFF, "R7");
      idle();
      // R2 / R1: perfect unicast entries
      set_uc(0, sta, 1);
      probe(sta, "R2");
      probe(sta + 48'd1, "R2");
      set_uc(15, 48'h0A_BB_CC_DD_EE_0F, 1);
      probe(48'h0A_BB_CC_DD_EE_0F, "R2");
      set_uc(15, 48'h0A_BB_CC_DD_EE_0F, 0);
      probe(48'h0A_BB_CC_DD_EE_0F, "R1");
      // hash addresses in each table half
      ma = pick_mcast(0);
      mb = pick_mcast(1);
      wr(1, 32'h1 << ref_index(ma)[4:0]);
      probe(ma, "R5");
      wr(0, 32'h4);
      probe(ma, "R4");
      probe(mb, "R4");
      wr(2, 32'h1 << ref_index(mb)[4:0]);
      probe(mb, "R4");
      wr(1, 32'h0);
      probe(ma, "R4");
      probe(48'hFFFF_FFFF_FFFF, "R7");
      // R6 pass-all-multicast
      wr(2, 32'h0);
      wr(0, 32'h2);
      probe(ma, "R6");
      probe(mb, "R6");
      probe(48'h02_99_99_99_99_99, "R6");
      // R3 promiscuous
      wr(0, 32'h1);
      probe(48'h02_99_99_99_99_99, "R3");
      probe(ma, "R3");
      // R8 receive-all
      wr(0, 32'h8);
      probe(48'h02_99_99_99_99_99, "R8");
      probe(sta, "R8");
      probe(ma, "R8");
      idle();
      idle();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule